// File: doc/BRIEF.md
# Floating-Point Symbol Rate Tick Generator

The block turns a fast reference clock into a stream of single-cycle symbol strobes. Its average rate is set by a small floating-point word, an 8-bit mantissa and a 4-bit exponent. The mantissa carries a hidden leading one, so the value that is scaled is always 256 plus the mantissa. A 28-bit phase accumulator adds that scaled value on every enabled clock. A strobe is produced each time the sum overflows. The strobe frequency is therefore (256 + mantissa) * 2^exponent / 2^28 of the clock, which gives fine resolution over a wide range of rates without a divider.

Software works out the mantissa and exponent for a wanted baud value. The block only consumes them. A new setting is taken up only when the accumulator wraps, so retuning while running never produces a short or doubled symbol. Dropping the enable discards the phase, and the next enable starts from a clean zero.

Top module: `symrate_gen`

## Requirements
- R1: While reset is asserted and after its release with enable low, sym_tick is 0.
- R2: The active increment is (256 + rate_mant) shifted left by rate_exp bits, with rate_mant an unsigned 8-bit value and rate_exp an unsigned 4-bit value. For example, mantissa 255 with exponent 15 gives a first strobe after 17 enabled cycles, and mantissa 0 with exponent 8 gives one after 4096.
- R3: While enabled, the 28-bit phase grows by the active increment on every clock. sym_tick is high for exactly the one cycle that follows each clock edge where that sum carried out of bit 27, and it is low in every other cycle.
- R4: Starting from a fresh enable, the number of strobes seen over 65536 cycles is within one of increment / 4096.
- R5: A change on rate_mant or rate_exp while enabled is adopted only at the edge where the accumulator wraps. The strobe already in progress keeps the old spacing, and the following interval uses the values present at that wrap edge.
- R6: With enable low, the phase is held at zero and sym_tick is 0 in the next cycle, even when a wrap would have happened at that edge. A later enable starts a full new period.
- R7: Two strobes never occur on consecutive cycles.
- R8: After enable rises, the first strobe appears in the cycle that follows the ceil(2^28 / increment)-th enabled edge (256 edges for exponent 12 with mantissa 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the accumulator; low clears the phase |
| rate_mant | input | 8 | Rate mantissa below the hidden leading one |
| rate_exp | input | 4 | Rate exponent, left shift of the mantissa |
| sym_tick | output | 1 | One-cycle symbol strobe |

## Verification
Two events can fall on the same clock edge. An accumulator wrap can meet a change of mantissa or exponent, and a wrap can meet the enable being dropped. The bench provokes both. It counts exactly 255 enabled cycles from a known zero phase and then changes the exponent, or lowers enable, just before the 256th edge, which is the wrap edge. It judges the outcome from the strobe timing: with a setting change, the strobe arrives on time and the next interval already uses the new value. With enable dropped, no strobe appears and the next enable takes a full period. A behavioural model runs alongside and is compared with the strobe on every cycle.

// File: rtl/symrate_pkg.sv
package symrate_pkg;
  // Width of the shifted increment: hidden one + mantissa + largest shift.
  function automatic int inc_width(input int mant_w, input int exp_w);
    return mant_w + 1 + (2 ** exp_w) - 1;
  endfunction
endpackage

// File: rtl/symrate_incr.sv
module symrate_incr #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int INC_W  = 24
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic [INC_W-1:0]  inc
);
  // Logarithmic shifter: one stage per exponent bit.
  logic [INC_W-1:0] stage [EXP_W+1];

  assign stage[0] = {{(INC_W-MANT_W-1){1'b0}}, 1'b1, mant};

  for (genvar s = 0; s < EXP_W; s++) begin : g_shift
    assign stage[s+1] = expo[s] ? (stage[s] << (2 ** s)) : stage[s];
  end

  assign inc = stage[EXP_W];
endmodule

// File: rtl/symrate_cfg_hold.sv
module symrate_cfg_hold #(
  parameter int INC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wrap,
  input  logic [INC_W-1:0] inc_new,
  output logic [INC_W-1:0] inc_q
);
  logic [INC_W-1:0] inc_d;
  logic             load;

  // Track inputs while idle; while running, reload only on a wrap.
  always_comb begin
    load  = !en || wrap;
    inc_d = load ? inc_new : inc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inc_q <= '0;
    else        inc_q <= inc_d;
  end
endmodule

// File: rtl/symrate_phase_acc.sv
module symrate_phase_acc #(
  parameter int ACC_W = 28,
  parameter int INC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic             wrap,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             tick_d;

  always_comb begin
    sum    = {1'b0, acc_q} + {{(ACC_W+1-INC_W){1'b0}}, inc};
    wrap   = en && sum[ACC_W];
    acc_d  = en ? sum[ACC_W-1:0] : '0;
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/symrate_gen.sv
module symrate_gen #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int ACC_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [MANT_W-1:0] rate_mant,
  input  logic [EXP_W-1:0]  rate_exp,
  output logic              sym_tick
);
  localparam int INC_W = symrate_pkg::inc_width(MANT_W, EXP_W);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [INC_W-1:0] inc_new;
  logic [INC_W-1:0] inc_q;
  logic             wrap;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  symrate_incr #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INC_W(INC_W)) u_incr (
    .mant (rate_mant),
    .expo (rate_exp),
    .inc  (inc_new)
  );

  symrate_cfg_hold #(.INC_W(INC_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (enable),
    .wrap    (wrap),
    .inc_new (inc_new),
    .inc_q   (inc_q)
  );

  symrate_phase_acc #(.ACC_W(ACC_W), .INC_W(INC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (enable),
    .inc   (inc_q),
    .wrap  (wrap),
    .tick  (sym_tick)
  );
endmodule

// File: rtl/symrate_gen_chk.sv
module symrate_gen_chk #(
  parameter int INC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             wrap,
  input logic [INC_W-1:0] inc,
  input logic             tick
);
  // R6: disabled cycle is followed by a quiet strobe
  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

  // R7: strobes are never adjacent
  p_no_adjacent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5: increment holds between wraps while running
  p_hold_between_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(inc));

  // R3: a carry yields a strobe in the next cycle
  p_tick_follows_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> tick);

  // R3: no strobe without a preceding carry
  p_no_tick_without_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> !tick);
endmodule

bind symrate_gen symrate_gen_chk #(.INC_W(INC_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .en    (enable),
  .wrap  (wrap),
  .inc   (inc_q),
  .tick  (sym_tick)
);

// File: tb/symrate_gen_bench.sv
`timescale 1ns/1ps
module symrate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] mant;
  logic [3:0] ex;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int adjacent = 0;
  bit done = 0;

  always #2 clk = ~clk;

  symrate_gen u_symrate_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (en),
    .rate_mant (mant),
    .rate_exp  (ex),
    .sym_tick  (tick)
  );

  // Behavioural reference model
  longint m_acc, m_inc, m_sum;
  bit     m_tick;
  localparam longint MODULUS = longint'(1) << 28;

  function automatic longint rate_inc(input int m, input int e);
    return longint'(256 + m) * (longint'(1) << e);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_inc = 0; m_tick = 0;
    end else if (!en) begin
      m_acc = 0; m_tick = 0; m_inc = rate_inc(mant, ex);
    end else begin
      m_sum  = m_acc + m_inc;
      m_tick = (m_sum >= MODULUS);
      m_acc  = m_sum % MODULUS;
      if (m_tick) m_inc = rate_inc(mant, ex);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R3: cycle-by-cycle comparison with the model
  bit prev_tick = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tick === m_tick, "R3 model", longint'(tick), longint'(m_tick));
      if (prev_tick && tick) adjacent++;
      prev_tick = tick;
    end
  end

  task automatic wait_tick(input int lim, output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!tick && cnt < lim);
  endtask

  task automatic start(input int m, input int e);
    @(negedge clk);
    en = 0; mant = 8'(m); ex = 4'(e);
    @(negedge clk);
    en = 1;
  endtask

  task automatic stop();
    @(negedge clk);
    en = 0;
    @(negedge clk);
  endtask

  task automatic window(input int m, input int e);
    int n;
    longint inc;
    n = 0;
    inc = rate_inc(m, e);
    start(m, e);
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
    chk((longint'(n) * 4096 - inc <= 4096) && (inc - longint'(n) * 4096 <= 4096),
        "R4 window count", n, inc / 4096);
    stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    rst_n = 0; en = 0; mant = 0; ex = 0;
    repeat (5) @(negedge clk);
    chk(tick == 0, "R1 in reset", tick, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(tick == 0, "R1 after release", tick, 0);

    // R8 first strobe latency, R3 steady period
    start(0, 12);
    wait_tick(1000, c); chk(c == 256, "R8 first latency", c, 256);
    wait_tick(1000, c); chk(c == 256, "R3 period", c, 256);
    stop();

    // R2 extremes and hidden leading one
    start(255, 15);
    wait_tick(100, c); chk(c == 17, "R2 max setting", c, 17);
    stop();
    start(0, 8);
    wait_tick(5000, c); chk(c == 4096, "R2 hidden one", c, 4096);
    stop();

    // R5 change mid-period
    start(0, 12);
    repeat (100) @(negedge clk);
    ex = 15;
    wait_tick(1000, c); chk(c == 156, "R5 old period kept", c, 156);
    wait_tick(1000, c); chk(c == 32, "R5 new period", c, 32);
    stop();

    // R5 change in the wrap cycle
    start(0, 12);
    repeat (255) @(negedge clk);
    ex = 15;
    wait_tick(1000, c); chk(c == 1, "R5 wrap-cycle strobe", c, 1);
    wait_tick(1000, c); chk(c == 32, "R5 wrap-cycle adopt", c, 32);
    stop();

    // R6 disable exactly at the wrap edge
    start(0, 12);
    repeat (255) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(tick == 0, "R6 disable at wrap", tick, 0);
    repeat (3) @(negedge clk);
    chk(tick == 0, "R6 idle quiet", tick, 0);
    en = 1;
    wait_tick(1000, c); chk(c == 256, "R6 fresh phase", c, 256);
    stop();

    // R4 average rate
    window(255, 15);
    window(37, 13);

    chk(adjacent == 0, "R7 adjacent strobes", adjacent, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule